// File: doc/BRIEF.md
# Byte-Accessed Up/Down Timer Counter

A 16-bit timer counter that sits on an 8-bit register bus. A CPU reaches the full counter value through two byte locations and a shared holding byte. Reading the low byte latches the matching high byte into the holding byte, and writing the low byte commits the holding byte and the bus byte together. Because of this, a 16-bit value always moves as one piece. A programmable 16-bit limit register is reached the same way.

A control byte selects what advances the counter and how it counts. The counter can be stopped, stepped by a one-cycle tick-enable from an external prescaler, or stepped by the rising or falling edges of an asynchronous pin. It can count up and wrap, count up to the limit and restart, or bounce between the limit and zero. A retrigger input asks for the action the counter takes at its limit. A sticky overflow flag, cleared by writing one, is gated by an enable bit onto an interrupt request.

Top module: `timer16`

## Requirements
- R1: After reset the counter and holding byte are 0, the limit is 0xFFFF, the control byte and overflow flag are 0, `is_bottom` is 1 and `irq` is 0.
- R2: A read strobe at address 0 returns counter bits 7:0 on `rdata` and, at the same edge, copies counter bits 15:8 into the holding byte; reads at address 1 or 3 return the holding byte.
- R3: A write at address 1 or 3 loads the holding byte; a write at address 0 loads the counter with {holding byte, `wdata`} in one edge.
- R4: A counter write (address 0) overrides any step, clear or direction change due in the same cycle.
- R5: Control bits 2:0 pick the step source: 0 stopped, 1 `tick_in`, 2 rising edges of `ext_pin`, 3 falling edges of `ext_pin`, 4 to 7 stopped. The pin passes a two-flop synchronizer and an edge detector, so a pin change set up before edge k steps the counter at edge k+2. The bus can read and write the counter while it is stopped.
- R6: With control bits 4:3 equal to 0 or 3, each step adds one; a step from 0xFFFF gives 0 and sets the overflow flag.
- R7: With control bits 4:3 equal to 1, a step adds one while the counter is below the limit; a step at or above the limit gives 0 and sets the overflow flag.
- R8: With control bits 4:3 equal to 2, the counter counts up and turns down when a step starts at or above the limit. A down step from 1 lands on 0 and sets the overflow flag. A down step from 0 turns the counter up again and gives 1. Outside this mode the direction is up.
- R9: `is_bottom` is 1 when the counter is 0. `is_top` is 1 when the counter equals the limit in modes 1 and 2, and when it equals 0xFFFF in modes 0 and 3.
- R10: A `retrig` pulse stays pending until the next step, which it replaces. In modes 0, 1 and 3 the counter is cleared without setting the flag. In mode 2 the direction turns down and the counter takes a down step.
- R11: Writing 1 to bit 0 at address 5 clears the overflow flag, and a set in the same cycle wins. Address 5 reads the flag in bit 0. `irq` is the flag ANDed with control bit 7.
- R12: Reading address 2 returns limit bits 7:0 and copies limit bits 15:8 into the holding byte. Writing address 2 loads the limit with {holding byte, `wdata`}. The control byte at address 4 keeps bits 7, 4:3 and 2:0 and reads the others as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| addr | input | 3 | register address |
| wr_en | input | 1 | write strobe |
| rd_en | input | 1 | read strobe (latches high bytes) |
| wdata | input | 8 | write data |
| rdata | output | 8 | read data, combinational from addr |
| tick_in | input | 1 | prescaler tick enable |
| ext_pin | input | 1 | asynchronous external count pin |
| retrig | input | 1 | retrigger request |
| is_top | output | 1 | counter at its limit |
| is_bottom | output | 1 | counter at zero |
| irq | output | 1 | overflow interrupt request |

## Verification
A wrong holding byte shows at the very next read of address 1 or 3. It also shows in the counter value after the next low-byte write, which the byte read ports then expose. A wrong count or direction shows in `is_top` and `is_bottom` within one step, and in the low byte on the same cycle. A missed or spurious overflow shows on `irq` one cycle after the step. A wrong synchronizer depth shifts every pin-driven step by a cycle, and the per-cycle comparison catches that shift at once.

// File: rtl/timer16.sv
`timescale 1ns/1ps
module timer16 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       tick_in,
  input  logic       ext_pin,
  input  logic       retrig,
  output logic       is_top,
  output logic       is_bottom,
  output logic       irq
);
  logic [15:0] cnt, top, nxt_cnt;
  logic [7:0]  tmp, ctrl;
  logic [2:0]  sync;
  logic        flag, dir_dn, pend, tick, nxt_dn, set_ovf;

  wire [2:0]  cs     = ctrl[2:0];
  wire [1:0]  mode   = ctrl[4:3];
  wire        wr_cnt = wr_en && addr == 3'd0;
  wire        step   = tick && !wr_cnt;
  wire        rt     = pend || retrig;
  wire [15:0] dn_val = (cnt == 16'd0) ? 16'd0 : cnt - 16'd1;
  wire        land   = cnt == 16'd1;

  always_comb begin
    case (cs)
      3'd1:    tick = tick_in;
      3'd2:    tick = sync[1] && !sync[2];
      3'd3:    tick = !sync[1] && sync[2];
      default: tick = 1'b0;
    endcase
  end

  always_comb begin
    nxt_cnt = cnt;
    nxt_dn  = dir_dn;
    set_ovf = 1'b0;
    if (mode == 2'd2) begin
      if (rt || (!dir_dn && cnt >= top)) begin
        nxt_dn = 1'b1; nxt_cnt = dn_val; set_ovf = land;
      end else if (dir_dn && cnt == 16'd0) begin
        nxt_dn = 1'b0; nxt_cnt = 16'd1;
      end else if (dir_dn) begin
        nxt_cnt = dn_val; set_ovf = land;
      end else begin
        nxt_cnt = cnt + 16'd1;
      end
    end else if (rt) begin
      nxt_cnt = 16'd0;
    end else if (mode == 2'd1 && cnt >= top) begin
      nxt_cnt = 16'd0; set_ovf = 1'b1;
    end else begin
      nxt_cnt = cnt + 16'd1; set_ovf = cnt == 16'hFFFF;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; top <= 16'hFFFF; tmp <= '0; ctrl <= '0;
      flag <= 1'b0; dir_dn <= 1'b0; pend <= 1'b0; sync <= '0;
    end else begin
      sync <= {sync[1:0], ext_pin};
      if (wr_cnt)    cnt <= {tmp, wdata};
      else if (step) cnt <= nxt_cnt;
      if (mode != 2'd2) dir_dn <= 1'b0;
      else if (step)    dir_dn <= nxt_dn;
      pend <= step ? 1'b0 : rt;
      if (wr_en && (addr == 3'd1 || addr == 3'd3)) tmp <= wdata;
      else if (rd_en && addr == 3'd0)              tmp <= cnt[15:8];
      else if (rd_en && addr == 3'd2)              tmp <= top[15:8];
      if (wr_en && addr == 3'd2) top  <= {tmp, wdata};
      if (wr_en && addr == 3'd4) ctrl <= wdata & 8'h9F;
      if (step && set_ovf)                          flag <= 1'b1;
      else if (wr_en && addr == 3'd5 && wdata[0])  flag <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = cnt[7:0];
      3'd1:    rdata = tmp;
      3'd2:    rdata = top[7:0];
      3'd3:    rdata = tmp;
      3'd4:    rdata = ctrl;
      3'd5:    rdata = {7'd0, flag};
      default: rdata = 8'd0;
    endcase
  end

  assign is_bottom = cnt == 16'd0;
  assign is_top    = (mode == 2'd1 || mode == 2'd2) ? cnt == top : cnt == 16'hFFFF;
  assign irq       = flag && ctrl[7];
endmodule

module timer16_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  addr,
  input logic        wr_en,
  input logic        rd_en,
  input logic [7:0]  wdata,
  input logic        tick_in,
  input logic        retrig,
  input logic [15:0] cnt,
  input logic [15:0] top,
  input logic [7:0]  tmp,
  input logic [7:0]  ctrl,
  input logic        flag,
  input logic        pend
);
  wire ctl_wr = wr_en && (addr == 3'd0 || addr == 3'd4);

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 3'd0 |=> cnt == {$past(tmp), $past(wdata)}); // R3
  AST_LOW_READ_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en && addr == 3'd0 |=> tmp == $past(cnt[15:8])); // R2
  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[2:0] == 3'd0 && !(wr_en && addr == 3'd0) |=> cnt == $past(cnt)); // R5
  AST_MODE0_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[4:3] == 2'd0 && ctrl[2:0] == 3'd1 && tick_in && !retrig && !pend && !ctl_wr
    |=> cnt == $past(cnt) + 16'd1); // R6
  AST_MODE1_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[4:3] == 2'd1 && cnt < top && !ctl_wr && !(wr_en && addr == 3'd2) |=> cnt <= top); // R7
  AST_RETRIG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[4:3] == 2'd0 && ctrl[2:0] == 3'd1 && tick_in && retrig && !ctl_wr |=> cnt == 16'd0); // R10
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !(wr_en && addr == 3'd5 && wdata[0]) |=> flag); // R11
endmodule

bind timer16 timer16_chk u_chk (.*);

// File: tb/timer16_tb.sv
`timescale 1ns/1ps
module timer16_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, tick_in = 1'b0, ext_pin = 1'b0, retrig = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic is_top, is_bottom, irq;

  int total = 0, bad = 0;
  string req = "R1";

  logic [15:0] m_cnt = 16'd0, m_top = 16'hFFFF;
  logic [7:0]  m_tmp = 8'd0, m_ctrl = 8'd0;
  bit m_flag = 0, m_dn = 0, m_pend = 0;
  bit pq[$] = '{0, 0, 0};

  always #4 clk = ~clk;

  timer16 u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .tick_in(tick_in), .ext_pin(ext_pin), .retrig(retrig),
    .is_top(is_top), .is_bottom(is_bottom), .irq(irq));

  task automatic model_step();
    int c, t, md, cs;
    bit tk, go, ov, ndn;
    c = m_cnt; t = m_top; md = m_ctrl[4:3]; cs = m_ctrl[2:0];
    if (cs == 1) tk = tick_in;
    else if (cs == 2) tk = pq[1] && !pq[2];
    else if (cs == 3) tk = !pq[1] && pq[2];
    else tk = 0;
    go = tk && !(wr_en && addr == 0);
    ov = 0; ndn = m_dn;
    if (go) begin
      if (md == 2) begin
        if (m_pend || retrig || (!m_dn && c >= t)) ndn = 1;
        else if (m_dn && c == 0) ndn = 0;
        if (ndn) begin
          ov = (c == 1);
          c = (c == 0) ? 0 : c - 1;
        end else c = c + 1;
      end else if (m_pend || retrig) c = 0;
      else if (md == 1 && c >= t) begin c = 0; ov = 1; end
      else begin c = (c + 1) % 65536; ov = (c == 0); end
    end
    if (wr_en && addr == 0) c = {m_tmp, wdata};
    if (wr_en && addr == 2) m_top = {m_tmp, wdata};
    if (wr_en && (addr == 1 || addr == 3)) m_tmp = wdata;
    else if (rd_en && addr == 0) m_tmp = m_cnt[15:8];
    else if (rd_en && addr == 2) m_tmp = t[15:8];
    if (ov) m_flag = 1;
    else if (wr_en && addr == 5 && wdata[0]) m_flag = 0;
    m_dn = (md == 2) ? (go ? ndn : m_dn) : 0;
    m_pend = go ? 0 : (m_pend || retrig);
    m_cnt = c[15:0];
    if (wr_en && addr == 4) m_ctrl = wdata & 8'h9F;
    pq.push_front(ext_pin);
    void'(pq.pop_back());
  endtask

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [7:0] er;
    int md;
    md = m_ctrl[4:3];
    case (addr)
      0: er = m_cnt[7:0];
      1, 3: er = m_tmp;
      2: er = m_top[7:0];
      4: er = m_ctrl;
      5: er = {7'd0, m_flag};
      default: er = 8'd0;
    endcase
    chk("rdata", rdata, er);
    chk("is_bottom R9", is_bottom, m_cnt == 0);
    chk("is_top R9", is_top, (md == 1 || md == 2) ? m_cnt == m_top : m_cnt == 16'hFFFF);
    chk("irq R11", irq, m_flag && m_ctrl[7]);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1; cyc(); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a);
    addr = a; rd_en = 1'b1; cyc(); rd_en = 1'b0;
  endtask

  task automatic set_cnt(input logic [15:0] v);
    bus_wr(3'd1, v[15:8]); bus_wr(3'd0, v[7:0]);
  endtask

  task automatic run(input int n); repeat (n) cyc(); endtask

  initial begin
    #1200000;
    total++; bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    req = "R1"; compare();
    bus_rd(3'd4); bus_rd(3'd5); bus_rd(3'd2); bus_rd(3'd3);

    req = "R12";
    bus_wr(3'd3, 8'h00); bus_wr(3'd2, 8'h05);
    bus_wr(3'd3, 8'hAA); bus_rd(3'd2); bus_rd(3'd3);
    bus_wr(3'd4, 8'hFF); bus_rd(3'd4);
    bus_wr(3'd4, 8'h00);

    req = "R6";
    set_cnt(16'hFFFC);
    bus_wr(3'd4, 8'h01);
    tick_in = 1'b1; run(6); tick_in = 1'b0;
    req = "R11";
    bus_wr(3'd4, 8'h81); bus_rd(3'd5);
    bus_wr(3'd5, 8'h00); bus_wr(3'd5, 8'h01); bus_rd(3'd5);

    req = "R2";
    bus_wr(3'd4, 8'h00);
    set_cnt(16'h3C5A);
    bus_wr(3'd1, 8'h00);
    bus_rd(3'd0); bus_rd(3'd1);

    req = "R3";
    set_cnt(16'hBEEF); bus_rd(3'd0); bus_rd(3'd1);

    req = "R4";
    bus_wr(3'd4, 8'h01); tick_in = 1'b1;
    set_cnt(16'h1234); bus_rd(3'd0); bus_rd(3'd1);
    tick_in = 1'b0;

    req = "R5";
    bus_wr(3'd4, 8'h00); tick_in = 1'b1; run(4);
    bus_wr(3'd4, 8'h04); run(4);
    set_cnt(16'h0010); addr = 3'd0;
    bus_wr(3'd4, 8'h02); tick_in = 1'b0;
    for (int i = 0; i < 24; i++) begin ext_pin = (i % 6) >= 3; cyc(); end
    bus_wr(3'd4, 8'h03);
    for (int i = 0; i < 24; i++) begin ext_pin = (i % 4) >= 2; cyc(); end
    ext_pin = 1'b0;
    bus_wr(3'd4, 8'h01);
    for (int i = 0; i < 12; i++) begin tick_in = (i % 3) == 0; cyc(); end
    tick_in = 1'b0;

    req = "R7";
    bus_wr(3'd4, 8'h09); bus_wr(3'd5, 8'h01);
    set_cnt(16'h0000); addr = 3'd0;
    tick_in = 1'b1; run(14);
    set_cnt(16'h0009); run(3); tick_in = 1'b0;

    req = "R8";
    bus_wr(3'd4, 8'h11); bus_wr(3'd5, 8'h01);
    set_cnt(16'h0002); addr = 3'd0;
    tick_in = 1'b1; run(22); tick_in = 1'b0;

    req = "R10";
    set_cnt(16'h0003); addr = 3'd0;
    tick_in = 1'b1; run(1); tick_in = 1'b0;
    retrig = 1'b1; cyc(); retrig = 1'b0; run(2);
    tick_in = 1'b1; run(6); tick_in = 1'b0;
    bus_wr(3'd4, 8'h01); set_cnt(16'h0100); addr = 3'd0;
    retrig = 1'b1; cyc(); retrig = 1'b0; run(2);
    tick_in = 1'b1; run(3);
    retrig = 1'b1; cyc(); retrig = 1'b0; run(2); tick_in = 1'b0;
    bus_wr(3'd4, 8'h09); set_cnt(16'h0002); addr = 3'd0;
    retrig = 1'b1; tick_in = 1'b1; cyc(); retrig = 1'b0; run(2); tick_in = 1'b0;

    req = "R11";
    bus_wr(3'd4, 8'h81); bus_wr(3'd5, 8'h01);
    set_cnt(16'hFFFF);
    tick_in = 1'b1; bus_wr(3'd5, 8'h01); tick_in = 1'b0;
    bus_rd(3'd5);
    bus_wr(3'd5, 8'h01); bus_rd(3'd5);

    req = "R9";
    bus_wr(3'd4, 8'h19); set_cnt(16'hFFFE); addr = 3'd0;
    tick_in = 1'b1; run(3); tick_in = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule